// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit signed arithmetic unit whose results clamp to the most positive or most negative representable value instead of wrapping around. It offers four saturating operations: add, subtract, and two "doubled" forms that first double the second operand (with its own clamp) and then add it to or subtract it from the first operand. A fifth operation counts the leading zero bits of the first operand.

Every clamp, whether in the doubling step or in the final add or subtract, raises a sticky saturation flag. The flag is exposed as one bit of a status word and stays set until a clear strobe removes it, so software can run a long sequence of operations and then ask once whether any of them lost precision. A small two-state machine owns the flag: state `FLG_IDLE` (flag low) and state `FLG_STICKY` (flag high). The transitions are SET (a saturating event, from either state, goes to `FLG_STICKY`), CLEAR (the clear strobe with no event in the same cycle goes to `FLG_IDLE`) and HOLD (anything else keeps the state).

An operation is presented with a valid strobe; the result register and the flag both update at the clock edge that samples the strobe, and the result holds its value on cycles without a valid operation.

Top module: `sat_alu`

## Requirements
- R1: Operation code 3'd0 gives the saturating sum opnd_a + opnd_b of the two signed 32-bit operands.
- R2: Operation code 3'd1 gives the saturating difference opnd_a - opnd_b.
- R3: Operation code 3'd2 doubles opnd_b with saturation, then adds the doubled value to opnd_a with saturation; a clamp in the doubling step alone still sets the flag.
- R4: Operation code 3'd3 doubles opnd_b with saturation, then subtracts the doubled value from opnd_a with saturation.
- R5: A true result above 0x7FFFFFFF yields 0x7FFFFFFF and one below -2^31 yields 0x80000000 (for example 0x70000000 + 0x7FFFFFFF gives 0x7FFFFFFF).
- R6: Any clamp during a valid operation sets the saturation flag, which appears at bit 27 of status_word; every other bit of status_word is 0.
- R7: The flag is sticky: it stays set across later operations that do not saturate and is cleared only by flag_clr (with no event in that cycle).
- R8: When flag_clr and a saturating event occur in the same cycle, the flag ends set.
- R9: Operation code 3'd4 returns the count of zero bits above the most significant one of opnd_a (0x00000010 gives 27, 0 gives 32, 0x80000000 gives 0) and never sets the flag.
- R10: result and the flag update at the rising edge that samples op_valid high; with op_valid low the result holds, and codes 3'd5 to 3'd7 leave both result and flag unchanged.
- R11: After reset, result is 0 and status_word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle it is high |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 doubled add, 3 doubled sub, 4 leading-zero count) |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Registered result of the last valid operation |
| status_word | output | 32 | Status word carrying the sticky flag at bit 27 |

## Verification
Both the result and the flag are due one clock edge after the inputs are presented: the bench drives on a falling edge, lets exactly one rising edge sample op_valid, and reads both outputs on the following falling edge before it changes any input. The flag's SET, CLEAR and HOLD transitions are each due on that same edge, so the sticky and same-cycle-clear checks read status_word one cycle after their strobe and again after an idle cycle. Holding checks (op_valid low, reserved codes) read the result a full cycle after the ignored stimulus, when any change it caused would already be visible.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    parameter int unsigned DATA_W   = 32;
    parameter int unsigned FLAG_POS = 27;

    localparam logic [2:0] OP_SADD = 3'd0;
    localparam logic [2:0] OP_SSUB = 3'd1;
    localparam logic [2:0] OP_DADD = 3'd2;
    localparam logic [2:0] OP_DSUB = 3'd3;
    localparam logic [2:0] OP_CLZ  = 3'd4;

    typedef enum logic [0:0] {
        FLG_IDLE   = 1'b0,
        FLG_STICKY = 1'b1
    } flag_state_e;

endpackage

// File: rtl/sat_double.sv
module sat_double #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         clamp
);
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        clamp = din[W-1] ^ din[W-2];
        if (clamp) begin
            dout = din[W-1] ? MIN_V : MAX_V;
        end else begin
            dout = {din[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         clamp
);
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic [W:0] lhs_x;
    logic [W:0] rhs_x;
    logic [W:0] wide;

    always_comb begin
        lhs_x = {lhs[W-1], lhs};
        rhs_x = {rhs[W-1], rhs};
        wide  = do_sub ? (lhs_x - rhs_x) : (lhs_x + rhs_x);
        clamp = wide[W] ^ wide[W-1];
        if (clamp) begin
            sum = wide[W] ? MIN_V : MAX_V;
        end else begin
            sum = wide[W-1:0];
        end
    end
endmodule

// File: rtl/lz_count.sv
module lz_count #(
    parameter int unsigned W     = 32,
    parameter int unsigned CNT_W = $clog2(W) + 1
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] zeros
);
    logic found;

    always_comb begin
        zeros = CNT_W'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                zeros = CNT_W'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_flag_fsm.sv
module sat_flag_fsm
    import sat_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sat_evt,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (sat_evt) state_d = FLG_STICKY;
            end
            FLG_STICKY: begin
                if (!sat_evt && clr_req) state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLG_STICKY);
    end

    // R6
    set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt |=> flag);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

    // R7
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !sat_evt) |=> !flag);

    // R8
    rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sat_evt));
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int unsigned W      = sat_alu_pkg::DATA_W,
    parameter int unsigned FLAG_B = sat_alu_pkg::FLAG_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_clr,
    output logic [W-1:0] result,
    output logic [W-1:0] status_word
);
    localparam int unsigned CNT_W = $clog2(W) + 1;
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]     dbl_val;
    logic             dbl_clamp;
    logic [W-1:0]     rhs_sel;
    logic             use_dbl;
    logic             do_sub;
    logic [W-1:0]     as_val;
    logic             as_clamp;
    logic [CNT_W-1:0] lz_val;
    logic [W-1:0]     res_d;
    logic             res_en;
    logic             sat_evt;
    logic             flag;

    sat_double #(.W(W)) u_dbl (
        .din   (opnd_b),
        .dout  (dbl_val),
        .clamp (dbl_clamp)
    );

    always_comb begin
        use_dbl = (op_sel == OP_DADD) || (op_sel == OP_DSUB);
        do_sub  = (op_sel == OP_SSUB) || (op_sel == OP_DSUB);
        rhs_sel = use_dbl ? dbl_val : opnd_b;
    end

    sat_addsub #(.W(W)) u_as (
        .lhs    (opnd_a),
        .rhs    (rhs_sel),
        .do_sub (do_sub),
        .sum    (as_val),
        .clamp  (as_clamp)
    );

    lz_count #(.W(W), .CNT_W(CNT_W)) u_lz (
        .vec   (opnd_a),
        .zeros (lz_val)
    );

    always_comb begin
        res_d   = result;
        res_en  = 1'b0;
        sat_evt = 1'b0;
        unique case (op_sel)
            OP_SADD, OP_SSUB: begin
                res_d   = as_val;
                res_en  = op_valid;
                sat_evt = op_valid && as_clamp;
            end
            OP_DADD, OP_DSUB: begin
                res_d   = as_val;
                res_en  = op_valid;
                sat_evt = op_valid && (as_clamp || dbl_clamp);
            end
            OP_CLZ: begin
                res_d   = {{(W-CNT_W){1'b0}}, lz_val};
                res_en  = op_valid;
            end
            default: begin
                res_d   = result;
                res_en  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result <= '0;
        else if (res_en) result <= res_d;
    end

    sat_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .sat_evt (sat_evt),
        .clr_req (flag_clr),
        .flag    (flag)
    );

    always_comb begin
        status_word         = '0;
        status_word[FLAG_B] = flag;
    end

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

    // R5
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel < 3'd4 && as_clamp) |=> (result == MAX_V || result == MIN_V));

    // R9
    lz_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CLZ && !flag) |=> !flag);

    // R3
    dbl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && use_dbl && dbl_clamp) |=> flag);
endmodule

// File: tb/tb_sat_alu.sv
module tb_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    sat_alu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_clr(flag_clr),
        .result(result), .status_word(status_word)
    );

    localparam logic [31:0] FLAG_W = 32'h0800_0000;
    localparam int NV = 19;
    // {op, a, b, expected result, expected flag}
    localparam logic [99:0] VEC [NV] = '{
        {3'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0}, // R1
        {3'd0, 32'h7000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1}, // R5
        {3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1}, // R5
        {3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0}, // R1
        {3'd1, 32'h0000_0010, 32'h0000_0030, 32'hFFFF_FFE0, 1'b0}, // R2
        {3'd1, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R2
        {3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1}, // R2
        {3'd1, 32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1}, // R2
        {3'd2, 32'h0000_0100, 32'h0000_0080, 32'h0000_0200, 1'b0}, // R3
        {3'd2, 32'hC000_0000, 32'h4000_0000, 32'h3FFF_FFFF, 1'b1}, // R3
        {3'd2, 32'h0000_0010, 32'hFFFF_FFF8, 32'h0000_0000, 1'b0}, // R3
        {3'd3, 32'h0000_0010, 32'h0000_0020, 32'hFFFF_FFD0, 1'b0}, // R4
        {3'd3, 32'h0000_0000, 32'hC000_0000, 32'h7FFF_FFFF, 1'b1}, // R4
        {3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1}, // R4
        {3'd4, 32'h0000_0010, 32'h1234_5678, 32'd27,        1'b0}, // R9
        {3'd4, 32'h0000_0000, 32'h0000_0000, 32'd32,        1'b0}, // R9
        {3'd4, 32'h8000_0000, 32'h0000_0000, 32'd0,         1'b0}, // R9
        {3'd4, 32'h0000_0001, 32'h0000_0000, 32'd31,        1'b0}, // R9
        {3'd2, 32'h7FFF_FFFF, 32'h3FFF_FFFF, 32'h7FFF_FFFF, 1'b1}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on a falling edge, one rising edge samples, return on the next falling edge
    task automatic apply(input logic v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic clr);
        @(negedge clk);
        op_valid = v; op_sel = op; opnd_a = a; opnd_b = b; flag_clr = clr;
        @(negedge clk);
        op_valid = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 result", result, 32'h0);
        check("R11 status", status_word, 32'h0);
        rst_n = 1'b1;

        // table walk: clear strobe with every vector, so the event decides the flag (R8)
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][99:97], VEC[i][96:65], VEC[i][64:33], 1'b1);
            check($sformatf("R1-table vec%0d result", i), result, VEC[i][32:1]);
            check($sformatf("R6 vec%0d status", i), status_word, VEC[i][0] ? FLAG_W : 32'h0);
        end

        // R7: sticky across non-saturating ops
        apply(1'b1, 3'd0, 32'h7FFF_FFFF, 32'h1, 1'b0);
        apply(1'b1, 3'd0, 32'h1, 32'h1, 1'b0);
        check("R7 sticky result", result, 32'h2);
        check("R7 sticky flag", status_word, FLAG_W);
        apply(1'b0, 3'd0, 32'h0, 32'h0, 1'b0);
        check("R7 sticky idle", status_word, FLAG_W);
        apply(1'b0, 3'd0, 32'h0, 32'h0, 1'b1);
        check("R7 clear alone", status_word, 32'h0);

        // R8: clear and event together
        apply(1'b1, 3'd1, 32'h8000_0000, 32'h5, 1'b1);
        check("R8 same-cycle flag", status_word, FLAG_W);
        check("R8 result", result, 32'h8000_0000);
        apply(1'b0, 3'd0, 32'h0, 32'h0, 1'b1);
        check("R8 later clear", status_word, 32'h0);

        // R9: leading-zero count with flag low leaves flag low
        apply(1'b1, 3'd4, 32'h0, 32'h0, 1'b0);
        check("R9 zero input", result, 32'd32);
        check("R9 no flag", status_word, 32'h0);

        // R10: hold when idle, reserved codes ignored
        apply(1'b1, 3'd0, 32'h100, 32'h23, 1'b0);
        check("R10 setup", result, 32'h123);
        apply(1'b0, 3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        check("R10 idle hold", result, 32'h123);
        check("R10 idle flag", status_word, 32'h0);
        for (int c = 5; c < 8; c++) begin
            apply(1'b1, 3'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
            check($sformatf("R10 reserved %0d result", c), result, 32'h123);
            check($sformatf("R10 reserved %0d flag", c), status_word, 32'h0);
        end

        // R3: doubling clamp alone sets flag even though final add fits
        apply(1'b1, 3'd2, 32'hF000_0000, 32'h5000_0000, 1'b0);
        check("R3 dbl-only result", result, 32'h6FFF_FFFF);
        check("R3 dbl-only flag", status_word, FLAG_W);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule